// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three digital supply-comparator flags into an ordered power-down response. The flags report that the supply has dropped below the warning level, below the minimum operating level, and below the battery level. They arrive asynchronously, so each is synchronised first. A priority decode then maps the three flags onto one of four supply levels: normal, warning, reset and battery. An ordering that cannot physically occur resolves to the deepest level whose flag is set.

On the first crossing out of the normal level, the block issues a single-cycle interrupt request, but only when the warning interrupt is enabled at that moment. From the reset level downward it holds the processor in reset, pulls an open-drain reset line low, and tells the memory decoder to force every chip enable and the write strobe inactive. The reset line is also sensed as an input. Another device pulling it low therefore resets this processor too, which keeps several parts in step through a power-down. At the battery level the block selects battery supply and drives a low-active power-fail flag.

A separate path debounces the program-request pin. It emits one bootstrap-request pulse for each accepted falling edge.

Top module: `pwr_supervisor`

## Requirements
- R1: While rst_ni is low, cpu_rst_o, rst_line_drive_o and ce_block_o are 1, pf_no is 1, and bat_sel_o, warn_irq_o and boot_req_o are 0.
- R2: When below_warn_i rises with warn_en_i high, warn_irq_o pulses high for exactly one clock, and cpu_rst_o stays 0.
- R3: A warning crossing that occurs with warn_en_i low produces no pulse, even if warn_en_i is raised later while the supply stays below the warning level.
- R4: Only one pulse is produced per crossing. A new pulse requires the supply to return to the normal level (all flags 0) first.
- R5: While below_min_i is 1, cpu_rst_o, rst_line_drive_o and ce_block_o are 1. They return to 0 once below_min_i clears and no deeper flag is set.
- R6: A low level on rst_line_i that is caused by another device sets cpu_rst_o and ce_block_o to 1, while rst_line_drive_o stays 0.
- R7: While below_bat_i is 1, bat_sel_o is 1, pf_no is 0, and reset stays asserted. When below_bat_i clears, bat_sel_o returns to 0 and pf_no to 1.
- R8: below_bat_i set with below_min_i and below_warn_i clear is treated as the battery level: bat_sel_o, cpu_rst_o and rst_line_drive_o are all 1.
- R9: prog_ni held low for at least DEB_CYCLES clocks produces exactly one boot_req_o pulse of one clock. Its release produces none.
- R10: A low excursion on prog_ni shorter than DEB_CYCLES produces no pulse. A bouncing press that settles low produces exactly one pulse.
- R11: A drop straight from the normal level to the reset level, with warn_en_i high, still produces exactly one warn_irq_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| below_warn_i | input | 1 | Supply below warning level (async) |
| below_min_i | input | 1 | Supply below minimum operating level (async) |
| below_bat_i | input | 1 | Supply below battery level (async) |
| warn_en_i | input | 1 | Warning interrupt enable |
| rst_line_i | input | 1 | Sensed level of the shared open-drain reset line (0 = asserted) |
| prog_ni | input | 1 | Program-request pin, active low (async) |
| warn_irq_o | output | 1 | One-clock warning interrupt request |
| cpu_rst_o | output | 1 | Processor reset |
| rst_line_drive_o | output | 1 | 1 pulls the shared reset line low |
| ce_block_o | output | 1 | Force chip enables and write strobe inactive |
| bat_sel_o | output | 1 | Output supply switched to battery |
| pf_no | output | 1 | Power-fail flag, low at battery level |
| boot_req_o | output | 1 | One-clock bootstrap request |

## Verification
The supply flags are applied in several patterns: warning alone, with the enable both set and clear; warning followed by recovery and a second drop; warning and minimum together; the full three-flag descent; and battery alone. Together these separate the cases of pulse versus no pulse, once-per-crossing versus re-arm, and priority decode versus a plain level copy. A reset line pulled low from outside, with the supply healthy, shows whether the line is sensed as an input apart from the block's own drive. On the program pin, a clean press, a short glitch and a bouncing press show whether the debouncer counts consecutive stable samples rather than raw edges.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  typedef enum logic [1:0] {
    LVL_NORMAL  = 2'd0,
    LVL_WARN    = 2'd1,
    LVL_RESET   = 2'd2,
    LVL_BATTERY = 2'd3
  } supply_lvl_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_level_fsm.sv
module pwr_level_fsm
  import pwr_sup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warn_s_i,
  input  logic        min_s_i,
  input  logic        bat_s_i,
  input  logic        warn_en_i,
  output supply_lvl_e lvl_o,
  output logic        warn_irq_o
);
  supply_lvl_e lvl_q, lvl_d;
  logic        irq_q;

  // deepest asserted flag wins, so impossible orderings resolve downward
  always_comb begin
    if (bat_s_i)       lvl_d = LVL_BATTERY;
    else if (min_s_i)  lvl_d = LVL_RESET;
    else if (warn_s_i) lvl_d = LVL_WARN;
    else               lvl_d = LVL_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_RESET;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= warn_en_i && (lvl_q == LVL_NORMAL) && (lvl_d != LVL_NORMAL);
    end
  end

  assign lvl_o      = lvl_q;
  assign warn_irq_o = irq_q;

  assert_irq_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |=> !warn_irq_o);

  assert_irq_leaves_normal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_irq_o |-> (lvl_q != LVL_NORMAL));
endmodule

// File: rtl/pwr_prog_debounce.sv
module pwr_prog_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic fall_o
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b1;
      fall_q   <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (pin_s_i == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        stable_q <= pin_s_i;
        fall_q   <= stable_q;  // accepted 1->0 only
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;

  assert_boot_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  assert_stable_needs_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_q != $past(stable_q)) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_warn_i,
  input  logic below_min_i,
  input  logic below_bat_i,
  input  logic warn_en_i,
  input  logic rst_line_i,
  input  logic prog_ni,
  output logic warn_irq_o,
  output logic cpu_rst_o,
  output logic rst_line_drive_o,
  output logic ce_block_o,
  output logic bat_sel_o,
  output logic pf_no,
  output logic boot_req_o
);
  logic [2:0]  flags_s;
  logic [1:0]  pins_s;
  supply_lvl_e lvl;
  logic        deep_rst;
  logic        ext_rst;

  // power-up assumption: below warning and minimum until sampled
  pwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_flag_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({below_bat_i, below_min_i, below_warn_i}),
    .q_o   (flags_s)
  );

  pwr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({prog_ni, rst_line_i}),
    .q_o   (pins_s)
  );

  pwr_level_fsm u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warn_s_i  (flags_s[0]),
    .min_s_i   (flags_s[1]),
    .bat_s_i   (flags_s[2]),
    .warn_en_i (warn_en_i),
    .lvl_o     (lvl),
    .warn_irq_o(warn_irq_o)
  );

  pwr_prog_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_prog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pins_s[1]),
    .fall_o (boot_req_o)
  );

  assign deep_rst         = (lvl == LVL_RESET) || (lvl == LVL_BATTERY);
  assign ext_rst          = ~pins_s[0];
  assign rst_line_drive_o = deep_rst;
  assign cpu_rst_o        = deep_rst | ext_rst;
  assign ce_block_o       = deep_rst | ext_rst;
  assign bat_sel_o        = (lvl == LVL_BATTERY);
  assign pf_no            = ~bat_sel_o;

  assert_bat_holds_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> (cpu_rst_o && rst_line_drive_o && !pf_no));

  assert_drive_blocks_ce_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_line_drive_o |-> (ce_block_o && cpu_rst_o));
endmodule

// File: tb/pwr_supervisor_bench.sv
module pwr_supervisor_bench;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn = 1'b0, minv = 1'b0, bat = 1'b0, en = 1'b0;
  logic ext_pull = 1'b0, prog_n = 1'b1;
  logic rst_line;
  logic warn_irq, cpu_rst, drive, ce_block, bat_sel, pf_n, boot_req;

  int checks = 0, failures = 0;
  int irq_cnt = 0, boot_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // open-drain wired line: low if this block or another device pulls
  assign rst_line = ~(drive | ext_pull);

  pwr_supervisor #(.DEB_CYCLES(DEB)) u_pwr_supervisor (
    .clk_i(clk), .rst_ni(rst_n),
    .below_warn_i(warn), .below_min_i(minv), .below_bat_i(bat),
    .warn_en_i(en), .rst_line_i(rst_line), .prog_ni(prog_n),
    .warn_irq_o(warn_irq), .cpu_rst_o(cpu_rst), .rst_line_drive_o(drive),
    .ce_block_o(ce_block), .bat_sel_o(bat_sel), .pf_no(pf_n),
    .boot_req_o(boot_req)
  );

  always @(posedge clk) begin
    if (warn_irq) irq_cnt <= irq_cnt + 1;
    if (boot_req) boot_cnt <= boot_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cpu_rst", cpu_rst, 1);
    chk("R1 drive", drive, 1);
    chk("R1 ce_block", ce_block, 1);
    chk("R1 pf_n", pf_n, 1);
    chk("R1 bat_sel", bat_sel, 0);
    chk("R1 warn_irq", warn_irq, 0);
    chk("R1 boot_req", boot_req, 0);
    rst_n = 1'b1;
    wait_cyc(10);
    chk("R5 released cpu_rst", cpu_rst, 0);
    chk("R1 no irq after reset", irq_cnt, 0);
  endtask

  task automatic t_warn_en;
    en = 1'b1; irq_cnt = 0;
    warn = 1'b1;
    wait_cyc(10);
    chk("R2 one pulse", irq_cnt, 1);
    chk("R2 runs on", cpu_rst, 0);
    wait_cyc(20);
    chk("R4 no repeat", irq_cnt, 1);
    warn = 1'b0;
    wait_cyc(10);
    warn = 1'b1;
    wait_cyc(10);
    chk("R4 rearm", irq_cnt, 2);
    warn = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_warn_dis;
    en = 1'b0; irq_cnt = 0;
    warn = 1'b1;
    wait_cyc(6);
    en = 1'b1;
    wait_cyc(10);
    chk("R3 disabled crossing", irq_cnt, 0);
    warn = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_min;
    en = 1'b1; irq_cnt = 0;
    warn = 1'b1; minv = 1'b1;
    wait_cyc(10);
    chk("R5 cpu_rst", cpu_rst, 1);
    chk("R5 drive", drive, 1);
    chk("R5 ce_block", ce_block, 1);
    chk("R11 direct drop pulse", irq_cnt, 1);
    minv = 1'b0;
    wait_cyc(10);
    chk("R5 recover cpu_rst", cpu_rst, 0);
    chk("R5 recover ce_block", ce_block, 0);
    chk("R4 no pulse on recovery", irq_cnt, 1);
    warn = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_ext;
    ext_pull = 1'b1;
    wait_cyc(10);
    chk("R6 cpu_rst", cpu_rst, 1);
    chk("R6 ce_block", ce_block, 1);
    chk("R6 no drive", drive, 0);
    ext_pull = 1'b0;
    wait_cyc(10);
    chk("R6 release", cpu_rst, 0);
  endtask

  task automatic t_bat;
    warn = 1'b1; minv = 1'b1; bat = 1'b1;
    wait_cyc(10);
    chk("R7 bat_sel", bat_sel, 1);
    chk("R7 pf_n", pf_n, 0);
    chk("R7 cpu_rst", cpu_rst, 1);
    bat = 1'b0;
    wait_cyc(10);
    chk("R7 bat_sel off", bat_sel, 0);
    chk("R7 pf_n high", pf_n, 1);
    chk("R7 still reset", cpu_rst, 1);
    warn = 1'b0; minv = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_odd;
    bat = 1'b1;
    wait_cyc(10);
    chk("R8 bat_sel", bat_sel, 1);
    chk("R8 cpu_rst", cpu_rst, 1);
    chk("R8 drive", drive, 1);
    bat = 1'b0;
    wait_cyc(10);
    chk("R8 recover", cpu_rst, 0);
  endtask

  task automatic t_prog;
    boot_cnt = 0;
    prog_n = 1'b0;
    wait_cyc(DEB + 10);
    chk("R9 press", boot_cnt, 1);
    prog_n = 1'b1;
    wait_cyc(DEB + 10);
    chk("R9 release", boot_cnt, 1);
    prog_n = 1'b0;
    wait_cyc(DEB / 2);
    prog_n = 1'b1;
    wait_cyc(DEB + 5);
    chk("R10 glitch", boot_cnt, 1);
    for (int i = 0; i < 3; i++) begin
      prog_n = 1'b0; wait_cyc(3);
      prog_n = 1'b1; wait_cyc(2);
    end
    prog_n = 1'b0;
    wait_cyc(DEB + 10);
    chk("R10 bounce", boot_cnt, 2);
    prog_n = 1'b1;
    wait_cyc(DEB + 10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_warn_en();
    t_warn_dis();
    t_min();
    t_ext();
    t_bat();
    t_odd();
    t_prog();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule